// File: doc/BRIEF.md
# Crank-Angle Position Counter

This block tracks the angular position of an engine shaft. A crank or cam encoder produces a square wave. The block brings that wave and a once-per-revolution index signal into the system clock domain and counts encoder events. The resulting count is the current shaft angle in encoder steps. It is driven onto an internal broadcast bus, and every match comparator in the ignition and injection timing array reads it from there. Each comparator fires its pulse-width timer when the angle equals its programmed value.

The counter can count only rising encoder edges, or it can count both edges, which doubles the angular resolution. A host-written mode bit selects between the two. The new setting is picked up at the next index, so a revolution never mixes two step sizes. A rising index edge returns the angle to zero and produces a one-clock revolution pulse. If the index is missing, the count holds at its terminal value instead of wrapping. A sticky flag then records the fault for the host.

Top module: `crank_angle_counter`

## Requirements
- R1: While reset is asserted and right after it is released, `pos_o` is 0, `rev_pulse_o` is 0, `miss_idx_o` is 0, and the counter is in single-edge mode.
- R2: In single-edge mode, each rising edge of `enc_i` increments `pos_o` by exactly one, and falling edges leave it unchanged. A level first sampled at clock edge k appears on `pos_o` after clock edge k+2.
- R3: In dual-edge mode, both the rising and the falling edges of `enc_i` increment `pos_o` by one each, with the same latency as R2.
- R4: A rising edge of `idx_i` forces `pos_o` to 0, with the same latency as R2. It takes priority over an encoder edge detected in the same cycle, and that encoder edge is not counted.
- R5: `rev_pulse_o` is high for exactly one clock for each rising edge of `idx_i`, and it is high in the first cycle in which `pos_o` shows the zero caused by that edge.
- R6: The mode is taken from `dual_edge_i` (0 = rising edges only, 1 = both edges) only at a rising edge of `idx_i`. Changing `dual_edge_i` between index edges does not change how encoder edges are counted.
- R7: `pos_o` never wraps. It holds at 2^CNT_W-1. `miss_idx_o` goes to 1 in the cycle the count reaches that value and stays at 1 until reset, including after a later index has cleared `pos_o`.
- R8: Holding `idx_i` high for many cycles zeroes the count only once. Encoder edges that arrive while the index is still high are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_i | input | 1 | Raw encoder square wave, asynchronous |
| idx_i | input | 1 | Once-per-revolution index, asynchronous |
| dual_edge_i | input | 1 | Host mode bit: 1 counts both encoder edges, picked up at the next index |
| pos_o | output | CNT_W | Current shaft angle, broadcast to the comparators |
| rev_pulse_o | output | 1 | One-clock pulse when the angle is zeroed by an index |
| miss_idx_o | output | 1 | Sticky flag: the angle reached its terminal value without an index |

## Verification
The bench builds the counter with CNT_W = 8, so the terminal value of 255 is only a few hundred encoder edges away. This makes the saturation and sticky missing-index behaviour reachable in a short run. The default 16-bit width would need far more edges than the cycle budget allows. The synchroniser depth stays at its default of 2. The bench therefore exercises the exact two-clock detection latency, and the case where an index edge and an encoder edge land on the same cycle.

// File: rtl/cac_pkg.sv
package cac_pkg;

    typedef enum logic {
        EDGE_RISE_ONLY = 1'b0,
        EDGE_BOTH      = 1'b1
    } edge_mode_e;

endpackage

// File: rtl/cac_edge_sync.sv
// Multi-lane synchroniser with edge detection in the system clock domain.
module cac_edge_sync #(
    parameter int N_LANES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_LANES-1:0] in_i,
    output logic [N_LANES-1:0] rise_o,
    output logic [N_LANES-1:0] fall_o
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain_d, chain_q;
        logic              prev_d, prev_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], in_i[g]};
            prev_d  = chain_q[LAST];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= chain_d;
                prev_q  <= prev_d;
            end
        end

        assign rise_o[g] =  chain_q[LAST] & ~prev_q;
        assign fall_o[g] = ~chain_q[LAST] &  prev_q;
    end
endmodule

// File: rtl/cac_mode_ctrl.sv
// Holds the active edge mode; reloads it from the host bit at an index edge.
module cac_mode_ctrl
    import cac_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       idx_rise_i,
    input  logic       dual_edge_i,
    output edge_mode_e mode_o
);
    edge_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (idx_rise_i) begin
            mode_d = edge_mode_e'(dual_edge_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mode_q <= EDGE_RISE_ONLY;
        else         mode_q <= mode_d;
    end

    assign mode_o = mode_q;

    AST_MODE_ONLY_AT_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(idx_rise_i) |-> $stable(mode_q)); // R6
endmodule

// File: rtl/cac_pos_core.sv
// Angle counter: zeroed by an index, advanced by encoder events, saturating.
module cac_pos_core
    import cac_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enc_rise_i,
    input  logic             enc_fall_i,
    input  logic             idx_rise_i,
    input  edge_mode_e       mode_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             rev_o,
    output logic             miss_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rev;
        logic             miss;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        step;

    always_comb begin
        step = enc_rise_i | ((mode_i == EDGE_BOTH) & enc_fall_i);
        st_d     = st_q;
        st_d.rev = 1'b0;
        if (idx_rise_i) begin
            st_d.cnt = '0;
            st_d.rev = 1'b1;
        end else if (step && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_MAX - 1'b1) begin
                st_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pos_o  = st_q.cnt;
    assign rev_o  = st_q.rev;
    assign miss_o = st_q.miss;

    AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rev_o && pos_o != $past(pos_o)) |-> (pos_o == $past(pos_o) + 1'b1)); // R2
    AST_REV_SHOWS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rev_o |-> (pos_o == '0)); // R4
    AST_REV_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rev_o |=> !rev_o); // R5
    AST_MISS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(miss_o) |-> miss_o); // R7
    AST_MAX_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_o == CNT_MAX) |-> miss_o); // R7
endmodule

// File: rtl/crank_angle_counter.sv
module crank_angle_counter
    import cac_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enc_i,
    input  logic             idx_i,
    input  logic             dual_edge_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             rev_pulse_o,
    output logic             miss_idx_o
);
    localparam int LANE_ENC = 0;
    localparam int LANE_IDX = 1;
    localparam int N_LANES  = 2;

    logic [N_LANES-1:0] raw, rise, fall;
    edge_mode_e         mode;

    assign raw[LANE_ENC] = enc_i;
    assign raw[LANE_IDX] = idx_i;

    cac_edge_sync #(.N_LANES(N_LANES), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .in_i   (raw),
        .rise_o (rise),
        .fall_o (fall)
    );

    cac_mode_ctrl mode_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .idx_rise_i  (rise[LANE_IDX]),
        .dual_edge_i (dual_edge_i),
        .mode_o      (mode)
    );

    cac_pos_core #(.CNT_W(CNT_W)) core_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enc_rise_i (rise[LANE_ENC]),
        .enc_fall_i (fall[LANE_ENC]),
        .idx_rise_i (rise[LANE_IDX]),
        .mode_i     (mode),
        .pos_o      (pos_o),
        .rev_o      (rev_pulse_o),
        .miss_o     (miss_idx_o)
    );

    AST_INDEX_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rev_pulse_o) |-> (pos_o == '0)); // R4
endmodule

// File: tb/crank_angle_counter_tb.sv
`timescale 1ns/1ps
module crank_angle_counter_tb_top;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc = 1'b0, idx = 1'b0, dual = 1'b0;
    logic [W-1:0] pos;
    logic rev, miss;

    int checks = 0, failures = 0;
    int rev_count = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    crank_angle_counter #(.CNT_W(W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enc_i(enc), .idx_i(idx),
        .dual_edge_i(dual), .pos_o(pos), .rev_pulse_o(rev), .miss_idx_o(miss)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: input history, then counting rules.
    int  m_cnt = 0;
    bit  m_rev = 0, m_miss = 0, m_mode = 0;
    bit  ea = 0, eb = 0, ec = 0, ia = 0, ib = 0, ic = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rev = 0; m_miss = 0; m_mode = 0;
            ea = 0; eb = 0; ec = 0; ia = 0; ib = 0; ic = 0;
        end else begin
            bit er, ef, ir;
            er = eb && !ec;
            ef = !eb && ec;
            ir = ib && !ic;
            if (ir) begin
                m_cnt = 0; m_rev = 1; m_mode = dual;
            end else begin
                m_rev = 0;
                if ((er || (m_mode && ef)) && m_cnt < MAX) begin
                    m_cnt++;
                    if (m_cnt == MAX) m_miss = 1;
                end
            end
            ec = eb; eb = ea; ea = enc;
            ic = ib; ib = ia; ia = idx;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pos == W'(m_cnt), "R2/R3/R4 pos vs model", int'(pos), m_cnt);
            check(rev == m_rev, "R5 rev vs model", int'(rev), int'(m_rev));
            check(miss == m_miss, "R7 miss vs model", int'(miss), int'(m_miss));
            if (rev) rev_count++;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n, input int hold);
        for (int i = 0; i < n; i++) begin
            enc = 1'b1; wait_clk(hold);
            enc = 1'b0; wait_clk(hold);
        end
    endtask

    task automatic index_pulse();
        idx = 1'b1; wait_clk(4);
        idx = 1'b0; wait_clk(5);
    endtask

    initial begin
        int rc;
        wait_clk(3);
        check(pos == 0 && rev == 0 && miss == 0, "R1 reset outputs", int'(pos), 0);
        @(negedge clk) rst_n = 1'b1;
        wait_clk(1);
        check(pos == 0 && rev == 0 && miss == 0, "R1 after release", int'(pos), 0);

        pulses(10, 3); wait_clk(5);
        check(pos == 10, "R2 single-edge count", int'(pos), 10);

        dual = 1'b1;
        pulses(2, 3); wait_clk(5);
        check(pos == 12, "R6 mode not taken before index", int'(pos), 12);

        rc = rev_count;
        idx = 1'b1; wait_clk(6);
        check(pos == 0, "R4 index zeroes", int'(pos), 0);
        pulses(2, 3); wait_clk(5);
        check(pos == 4, "R8 held index, R3 dual count", int'(pos), 4);
        idx = 1'b0; wait_clk(5);
        check(rev_count == rc + 1, "R5 one pulse per index", rev_count, rc + 1);
        check(rev_count == rc + 1, "R8 no retrigger while held", rev_count, rc + 1);

        pulses(6, 3); wait_clk(5);
        check(pos == 16, "R3 dual-edge count", int'(pos), 16);

        dual = 1'b0;
        pulses(5, 3); wait_clk(5);
        check(pos == 26, "R6 change mid-revolution ignored", int'(pos), 26);

        index_pulse();
        check(pos == 0, "R4 index clears", int'(pos), 0);
        pulses(5, 3); wait_clk(5);
        check(pos == 5, "R6 single mode after index", int'(pos), 5);

        enc = 1'b1; idx = 1'b1; wait_clk(6);
        check(pos == 0, "R4 index beats same-cycle encoder edge", int'(pos), 0);
        enc = 1'b0; idx = 1'b0; wait_clk(6);
        check(pos == 0, "R4 falling edge ignored in single mode", int'(pos), 0);

        pulses(100, 2); wait_clk(5);
        check(pos == 100 && miss == 0, "R7 no flag below max", int'(pos), 100);
        pulses(200, 2); wait_clk(5);
        check(pos == MAX, "R7 saturates", int'(pos), MAX);
        check(miss == 1, "R7 flag set", int'(miss), 1);

        rc = rev_count;
        index_pulse();
        check(pos == 0, "R7 index clears count", int'(pos), 0);
        check(miss == 1, "R7 flag sticky after index", int'(miss), 1);
        check(rev_count == rc + 1, "R5 pulse on index", rev_count, rc + 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule